// File: doc/BRIEF.md
# Fan Tachometer Period Checker

This block times the pulse train coming from a fan's tachometer output and reports each interval between rising edges as a count of system clock cycles. The asynchronous tach pin is brought into the clock domain through a two-flop synchroniser. An edge detector feeds a saturating counter, which emits one measurement for every completed period. A measurement of zero stands for "nothing measured yet". Software turns the count into a rotation speed on its own, using the fan's pulses per revolution (1, 2 or 4).

Each measurement is compared with a window of expected period plus or minus a tolerance, and a result outside that window raises a one-cycle error pulse. Software normally loads the expected period from a fresh measurement and sets the tolerance to about a quarter of it. While the duty cycle is being changed by the hardware's own temperature control, built-in default values replace the software registers. During the settling time after a duty change, the judging is switched off. A fan that stops is caught when the counter saturates. The block then reports the saturated count once and flags it as an error.

Top module: `fan_tach_monitor`

## Requirements
- R1: The tach input passes through two synchroniser flops, and each rising edge is detected once. The reported value is the number of clock cycles between two consecutive rising edges of `tach_in` when each level of the pin lasts at least two cycles.
- R2: The first rising edge after reset, and the first after a stall report, only starts timing and produces no report.
- R3: Each report pulses `new_meas_o` for exactly one cycle, with `meas_o` updated on the same edge. The pulse is seen after the fourth rising clock edge that follows the rising edge of `tach_in`. Between reports `meas_o` holds its value.
- R4: A report raises `tach_err_o` when the value is below period minus tolerance or above period plus tolerance. Both bounds are inclusive, so a value equal to a bound passes. When the tolerance exceeds the period, the lower bound is zero.
- R5: When `hw_change_i` is 1 in the cycle a report is judged, the parameters `HW_PERIOD` and `HW_TOL` replace `sw_period_i` and `sw_tol_i`.
- R6: `meas_o` is zero from reset until the first report, and no report carries the value zero.
- R7: If the counter reaches 2^CNT_W-1 with no edge, one report of that value is made, with an error. No further report follows until edges resume.
- R8: When `settling_i` is 1 in the cycle a report is judged, `tach_err_o` stays 0 but the measurement is still published.
- R9: `tach_err_o` is only ever high together with `new_meas_o`.
- R10: After reset, `new_meas_o`, `tach_err_o` and `meas_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_in | input | 1 | Asynchronous fan tachometer pin |
| sw_period_i | input | CNT_W | Software expected period in cycles |
| sw_tol_i | input | CNT_W | Software tolerance in cycles |
| hw_change_i | input | 1 | 1 while a hardware-initiated duty change is in effect |
| settling_i | input | 1 | 1 during the post-change settling window |
| meas_o | output | CNT_W | Last reported period in cycles |
| new_meas_o | output | 1 | One-cycle pulse on each report |
| tach_err_o | output | 1 | One-cycle pulse on a report outside the window |

## Verification
The assertions check on every cycle that an edge pulse never lasts two cycles and that a saturated counter stays saturated. They also check that no report is zero, that the error pulse appears only with a report, that settling masks the error, that a stall while judging is active always errs, and that the measurement register holds between reports. Only the bench scenarios can show the exact period values and the four-edge latency. The same holds for the inclusive window bounds, the clamped lower bound, the swap to the built-in defaults, the silent first edge and the single report on a stall. The bench reaches these by comparing every report against a queue of expected values, built as it drives randomised and directed pulse trains.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    typedef enum logic [1:0] {
        VERDICT_OK    = 2'd0,
        VERDICT_LOW   = 2'd1,
        VERDICT_HIGH  = 2'd2,
        VERDICT_STALL = 2'd3
    } verdict_e;

    typedef struct packed {
        logic [31:0] period;
        logic [31:0] tol;
    } ref_window_t;

    function automatic verdict_e classify(input logic [31:0] meas,
                                          input ref_window_t win,
                                          input logic stall);
        logic [32:0] hi;
        logic [32:0] lo;
        hi = {1'b0, win.period} + {1'b0, win.tol};
        lo = (win.period > win.tol) ? {1'b0, win.period - win.tol} : 33'd0;
        if (stall)
            return VERDICT_STALL;
        else if ({1'b0, meas} < lo)
            return VERDICT_LOW;
        else if ({1'b0, meas} > hi)
            return VERDICT_HIGH;
        return VERDICT_OK;
    endfunction

endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tach_async,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= tach_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

    // R1: one detected edge never spans two cycles
    p_rise_single_r1: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tach_period_counter.sv
module tach_period_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    output logic             stb_o,
    output logic [CNT_W-1:0] value_o,
    output logic             stall_o
);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             stalled_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            armed_q   <= 1'b0;
            stalled_q <= 1'b0;
            stb_o     <= 1'b0;
            value_o   <= '0;
            stall_o   <= 1'b0;
        end else begin
            stb_o   <= 1'b0;
            stall_o <= 1'b0;
            if (rise_i) begin
                if (armed_q && !stalled_q) begin
                    stb_o   <= 1'b1;
                    value_o <= cnt_q;
                end
                armed_q   <= 1'b1;
                stalled_q <= 1'b0;
                cnt_q     <= {{(CNT_W-1){1'b0}}, 1'b1};
            end else if (cnt_q == FULL) begin
                if (!stalled_q) begin
                    stb_o     <= 1'b1;
                    value_o   <= FULL;
                    stall_o   <= 1'b1;
                    stalled_q <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R7: a saturated count does not wrap while no edge arrives
    p_sat_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == FULL && !rise_i) |=> (cnt_q == FULL));

    // R7: the stall report is a single event
    p_stall_once_r7: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> !stall_o);

    // R6: a report never carries zero
    p_report_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        stb_o |-> (value_o != '0));

endmodule

// File: rtl/tach_window_judge.sv
module tach_window_judge
    import fan_tach_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int HW_PERIOD = 20000,
    parameter int HW_TOL    = 5000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb_i,
    input  logic [CNT_W-1:0] value_i,
    input  logic             stall_i,
    input  logic [CNT_W-1:0] sw_period_i,
    input  logic [CNT_W-1:0] sw_tol_i,
    input  logic             hw_sel_i,
    input  logic             settle_i,
    output logic [CNT_W-1:0] meas_o,
    output logic             new_meas_o,
    output logic             err_o
);
    localparam int PAD = 32 - CNT_W;

    ref_window_t win;
    verdict_e    verdict;

    always_comb begin
        if (hw_sel_i) begin
            win.period = 32'(HW_PERIOD);
            win.tol    = 32'(HW_TOL);
        end else begin
            win.period = {{PAD{1'b0}}, sw_period_i};
            win.tol    = {{PAD{1'b0}}, sw_tol_i};
        end
        verdict = classify({{PAD{1'b0}}, value_i}, win, stall_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meas_o     <= '0;
            new_meas_o <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            new_meas_o <= stb_i;
            err_o      <= stb_i && !settle_i && (verdict != VERDICT_OK);
            if (stb_i) meas_o <= value_i;
        end
    end

    // R9: error only accompanies a report
    p_err_with_meas_r9: assert property (@(posedge clk) disable iff (rst)
        err_o |-> new_meas_o);

    // R8: settling masks the error
    p_settle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        settle_i |=> !err_o);

    // R7: a stall judged outside settling always errs
    p_stall_err_r7: assert property (@(posedge clk) disable iff (rst)
        (stb_i && stall_i && !settle_i) |=> err_o);

    // R3: measurement holds between reports
    p_meas_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> $stable(meas_o));

    // R6: published value is never zero
    p_pub_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        new_meas_o |-> (meas_o != '0));

endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor #(
    parameter int CNT_W     = 16,
    parameter int HW_PERIOD = 20000,
    parameter int HW_TOL    = 5000,
    parameter int SYNC_LEN  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tach_in,
    input  logic [CNT_W-1:0] sw_period_i,
    input  logic [CNT_W-1:0] sw_tol_i,
    input  logic             hw_change_i,
    input  logic             settling_i,
    output logic [CNT_W-1:0] meas_o,
    output logic             new_meas_o,
    output logic             tach_err_o
);
    logic             rise;
    logic             stb;
    logic             stall;
    logic [CNT_W-1:0] value;

    tach_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .tach_async (tach_in),
        .rise_o     (rise)
    );

    tach_period_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .rise_i  (rise),
        .stb_o   (stb),
        .value_o (value),
        .stall_o (stall)
    );

    tach_window_judge #(
        .CNT_W     (CNT_W),
        .HW_PERIOD (HW_PERIOD),
        .HW_TOL    (HW_TOL)
    ) u_judge (
        .clk         (clk),
        .rst         (rst),
        .stb_i       (stb),
        .value_i     (value),
        .stall_i     (stall),
        .sw_period_i (sw_period_i),
        .sw_tol_i    (sw_tol_i),
        .hw_sel_i    (hw_change_i),
        .settle_i    (settling_i),
        .meas_o      (meas_o),
        .new_meas_o  (new_meas_o),
        .err_o       (tach_err_o)
    );

endmodule

// File: tb/fan_tach_monitor_tb_top.sv
module fan_tach_monitor_tb_top;
    localparam int CW   = 12;
    localparam int HWP  = 200;
    localparam int HWT  = 50;
    localparam int FULL = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tach_in = 1'b0;
    logic [CW-1:0] sw_period = '0;
    logic [CW-1:0] sw_tol = '0;
    logic          hw_change = 1'b0;
    logic          settling = 1'b0;
    logic [CW-1:0] meas;
    logic          new_meas;
    logic          tach_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int unsigned q_val[$];
    bit          q_err[$];
    bit          q_stall[$];
    longint      q_time[$];

    bit     armed = 0;
    longint last_rise = 0;

    always #2 clk = ~clk;

    fan_tach_monitor #(.CNT_W(CW), .HW_PERIOD(HWP), .HW_TOL(HWT)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .tach_in     (tach_in),
        .sw_period_i (sw_period),
        .sw_tol_i    (sw_tol),
        .hw_change_i (hw_change),
        .settling_i  (settling),
        .meas_o      (meas),
        .new_meas_o  (new_meas),
        .tach_err_o  (tach_err)
    );

    function automatic bit exp_err(int unsigned m);
        int unsigned p, t, lo;
        if (settling) return 0;
        p  = hw_change ? HWP : int'(sw_period);
        t  = hw_change ? HWT : int'(sw_tol);
        lo = (p > t) ? p - t : 0;
        return (m < lo) || (m > p + t);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one rising edge followed by a full period of length per cycles
    task automatic pulse(int per, int high);
        longint now_cyc;
        int unsigned iv;
        now_cyc = $time / 4;
        if (armed) begin
            iv = int'(now_cyc - last_rise);
            q_val.push_back(iv);
            q_err.push_back(exp_err(iv));
            q_stall.push_back(0);
            q_time.push_back($time);
        end
        armed = 1;
        last_rise = now_cyc;
        tach_in = 1'b1;
        repeat (high) @(negedge clk);
        tach_in = 1'b0;
        repeat (per - high) @(negedge clk);
    endtask

    // hold the pin low long enough to stall (R7)
    task automatic stall_wait(int n);
        if ((($time / 4) + n - last_rise) > FULL + 8) begin
            q_val.push_back(FULL);
            q_err.push_back(!settling);
            q_stall.push_back(1);
            q_time.push_back(0);
            armed = 0;
        end
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (tach_err && !new_meas)
                check(0, "R9", tach_err, 0);
            if (new_meas) begin
                if (q_val.size() == 0) begin
                    check(0, "R2/R7 unexpected report", meas, 0);
                end else begin
                    int unsigned ev;
                    bit ee, es;
                    longint et;
                    ev = q_val.pop_front();
                    ee = q_err.pop_front();
                    es = q_stall.pop_front();
                    et = q_time.pop_front();
                    check(meas == CW'(ev), es ? "R7 value" : "R1 value", meas, ev);
                    check(tach_err == ee, es ? "R7 err" : "R4/R5/R8 err", tach_err, ee);
                    if (!es)
                        check(($time - et) == 16, "R3 latency", ($time - et) / 4, 4);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(meas == 0, "R10/R6 meas", meas, 0);
        check(new_meas == 0, "R10 new", new_meas, 0);
        check(tach_err == 0, "R10 err", tach_err, 0);

        // R2: first edge silent; R4 inclusive bounds
        sw_period = 100; sw_tol = 10;
        pulse(90, 40);
        check(q_val.size() == 0, "R2 first edge", q_val.size(), 0);
        pulse(111, 50); pulse(110, 50); pulse(89, 40); pulse(100, 50);
        // R4 lower bound clamp
        sw_period = 5; sw_tol = 20;
        pulse(4, 2); pulse(25, 10); pulse(26, 10);
        // R5 hardware defaults replace sw values
        sw_period = 1000; sw_tol = 10;
        hw_change = 1;
        pulse(200, 90); pulse(150, 60); pulse(251, 100); pulse(149, 60);
        hw_change = 0;
        // R8 settling masks error but reports
        settling = 1;
        pulse(30, 10); pulse(30, 10);
        settling = 0;
        pulse(30, 10);
        // R7 stall, judged active
        stall_wait(FULL + 600);
        check(q_val.size() == 0, "R7 single report", q_val.size(), 0);
        pulse(50, 20); pulse(50, 20); pulse(60, 20);
        // R7 stall during settling: no error
        settling = 1;
        stall_wait(FULL + 300);
        settling = 0;
        pulse(40, 20); pulse(40, 20);
        // constrained random
        for (int i = 0; i < 80; i++) begin
            int per, high;
            per  = 4 + int'($urandom_range(0, 396));
            high = 2 + int'($urandom_range(0, per - 4));
            sw_period = CW'(per + int'($urandom_range(0, 120)) - 60 + 100);
            sw_tol    = CW'($urandom_range(0, 100));
            hw_change = ($urandom_range(0, 3) == 0);
            settling  = ($urandom_range(0, 4) == 0);
            pulse(per, high);
        end
        hw_change = 0; settling = 0;
        pulse(20, 10);
        repeat (10) @(negedge clk);
        check(q_val.size() == 0, "R3 all reports seen", q_val.size(), 0);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule